// File: doc/BRIEF.md
# Serial Transceiver with Pass-Through Ninth Bit

This block sends and receives asynchronous serial frames. It takes its bit timing from an external enable that pulses at sixteen times the baud rate. A single seven-bit configuration word sets the data width (seven or eight bits) and turns an optional extra bit on or off. The same word selects an eight-entry receive queue or a single holding slot, sets three interrupt masks, and drives the request-to-send line. The extra bit is never computed. The transmitter sends it exactly as the host supplies it. The receiver keeps it with each received byte, so a host on an addressed multi-drop network can tell address frames from data frames.

The host writes one byte and an extra bit to start a transmission. It reads received entries from the head of the queue. The head entry is always visible on the read outputs and a read strobe removes it. An active-low interrupt combines the data-available flag, the head entry's extra bit and an overrun/framing error flag, each gated by its own mask. Clear-to-send is only reported as a status bit.

Top module: `uart9_core`

## Requirements
- R1: A transmit strobe while idle sends a start bit (0), the data bits least significant first, and a stop bit (1), each 16 ticks long. `txBusy` is high for the whole frame and `serOut` rests at 1 when idle.
- R2: With configuration bit 0 set (short word), the transmitter sends only data bits 0..6. Bit 7 of the written byte is not sent.
- R3: With configuration bit 1 set (extra bit on), `txExtra` goes on the line as written, right after the last data bit and before the stop bit. No parity is calculated. With bit 1 clear, no extra bit is sent and `txExtra` has no effect.
- R4: With configuration bit 1 set, the receiver expects one bit after the data bits and stores it with the byte, shown on `rxExtra`. With bit 1 clear, `rxExtra` reads 0.
- R5: With configuration bit 0 set, the receiver takes seven data bits and `rxData[7]` reads 0.
- R6: With configuration bit 2 clear, received entries are kept in an 8-entry queue and read back in arrival order. A frame that arrives while all 8 entries are full is dropped and sets `errFlag`.
- R7: With configuration bit 2 set, only one entry is held. A second frame that arrives before the first is read is dropped and sets `errFlag`.
- R8: While nothing is stored, `rxAvail` is 0 and `rxData`/`rxExtra` read 0. `rxAvail` falls when the last stored entry is read with `rxRe`.
- R9: `irqN` is low exactly when (bit 3 and `rxAvail`) or (bit 4 and `rxExtra`) or (bit 5 and `errFlag`) holds.
- R10: Configuration bit 6 = 1 drives `rtsN` low and 0 drives it high. `ctsStat` reads 0 while `ctsN` is high and 1 while it is low.
- R11: A frame whose stop bit is sampled low is discarded and sets `errFlag`.
- R12: After reset all configuration bits are 0: `rtsN` and `irqN` are high, `serOut` is 1, and nothing is stored.
- R13: A read strobe clears `errFlag`. A new error in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the baud rate |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 7 | Configuration word (bit0 short, bit1 extra, bit2 bypass queue, bit3..5 masks, bit6 RTS) |
| txWe | input | 1 | Start transmission, accepted when idle |
| txData | input | 8 | Byte to transmit |
| txExtra | input | 1 | Extra bit to transmit |
| txBusy | output | 1 | Transmitter is sending a frame |
| rxRe | input | 1 | Read strobe: pops the head entry, clears error |
| rxData | output | 8 | Head entry data, zero when empty |
| rxExtra | output | 1 | Head entry extra bit, zero when empty |
| rxAvail | output | 1 | Unread data present |
| errFlag | output | 1 | Overrun or framing error |
| serIn | input | 1 | Serial receive line |
| serOut | output | 1 | Serial transmit line |
| ctsN | input | 1 | Active-low clear-to-send pin |
| ctsStat | output | 1 | Clear-to-send status |
| rtsN | output | 1 | Active-low request-to-send pin |
| irqN | output | 1 | Active-low interrupt |

## Verification
The hardest conditions to reach are overrun in both storage modes and the framing error. Each one needs whole serial frames with exact bit timing on the receive line. The bench has a bit-level line driver that sends nine back-to-back frames into the queue without any read in between, and two frames into the single holding slot. It also sends one frame whose stop bit is forced low. After each case it checks the error flag, the retained data and the interrupt at the ports.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = DATA_W + 1;
  localparam int FRAME_W = DATA_W + 3;
  localparam int OVS     = 16;
  localparam int HALF    = OVS / 2;
  localparam int TICK_W  = $clog2(OVS);
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int CFG_W   = 7;

  typedef struct packed {
    logic rtsOn;
    logic maskErr;
    logic maskExtra;
    logic maskRx;
    logic fifoOff;
    logic extraEn;
    logic shortWord;
  } cfg_t;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxSample;
    logic rxPush;
    logic rxPop;
    logic errSet;
    logic errClr;
    logic frmShort;
    logic frmExtra;
  } strobe_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
  import uart9_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgIn,
  input  logic             txWe,
  input  logic             rxRe,
  input  logic             rxLine,
  input  logic             rxFull,
  input  logic             rxEmpty,
  output cfg_t             cfg,
  output strobe_t          stb,
  output logic             txBusy
);
  // configuration word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (cfgWe) cfg <= cfg_t'(cfgIn);
  end

  // transmit sequencer
  logic              txActive;
  logic [TICK_W-1:0] txTick;
  logic [BIT_W-1:0]  txBitIdx;
  logic [BIT_W-1:0]  txLast;
  logic              txStart;
  logic              txEndBit;

  assign txStart  = txWe && !txActive;
  assign txEndBit = txActive && tick && (txTick == TICK_W'(OVS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txTick   <= '0;
      txBitIdx <= '0;
      txLast   <= '0;
    end else if (txStart) begin
      txActive <= 1'b1;
      txTick   <= '0;
      txBitIdx <= '0;
      txLast   <= BIT_W'(DATA_W + 1) - BIT_W'(cfg.shortWord) + BIT_W'(cfg.extraEn);
    end else if (txActive && tick) begin
      if (txEndBit) begin
        txTick <= '0;
        if (txBitIdx == txLast) txActive <= 1'b0;
        else txBitIdx <= txBitIdx + BIT_W'(1);
      end else begin
        txTick <= txTick + TICK_W'(1);
      end
    end
  end

  assign txBusy = txActive;

  // receive sequencer
  rx_state_e         rxState;
  logic [TICK_W-1:0] rxTick;
  logic [BIT_W-1:0]  rxBitIdx;
  logic [BIT_W-1:0]  rxLast;
  logic              rxShortL;
  logic              rxExtraL;
  logic              rxBitEnd;
  logic              rxHalf;

  assign rxBitEnd = tick && (rxTick == TICK_W'(OVS - 1));
  assign rxHalf   = tick && (rxTick == TICK_W'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxTick   <= '0;
      rxBitIdx <= '0;
      rxLast   <= '0;
      rxShortL <= 1'b0;
      rxExtraL <= 1'b0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (tick && !rxLine) begin
            rxState  <= RX_START;
            rxTick   <= '0;
            rxShortL <= cfg.shortWord;
            rxExtraL <= cfg.extraEn;
            rxLast   <= BIT_W'(DATA_W - 1) - BIT_W'(cfg.shortWord) + BIT_W'(cfg.extraEn);
          end
        end
        RX_START: begin
          if (rxHalf) begin
            rxTick   <= '0;
            rxBitIdx <= '0;
            rxState  <= rxLine ? RX_IDLE : RX_BITS;
          end else if (tick) begin
            rxTick <= rxTick + TICK_W'(1);
          end
        end
        RX_BITS: begin
          if (rxBitEnd) begin
            rxTick <= '0;
            if (rxBitIdx == rxLast) rxState <= RX_STOP;
            else rxBitIdx <= rxBitIdx + BIT_W'(1);
          end else if (tick) begin
            rxTick <= rxTick + TICK_W'(1);
          end
        end
        RX_STOP: begin
          if (rxBitEnd) begin
            rxTick  <= '0;
            rxState <= RX_IDLE;
          end else if (tick) begin
            rxTick <= rxTick + TICK_W'(1);
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  logic stopNow;
  assign stopNow = (rxState == RX_STOP) && rxBitEnd;

  always_comb begin
    stb          = '0;
    stb.txLoad   = txStart;
    stb.txShift  = txEndBit;
    stb.rxSample = (rxState == RX_BITS) && rxBitEnd;
    stb.rxPush   = stopNow && rxLine && !rxFull;
    stb.errSet   = stopNow && (!rxLine || rxFull);
    stb.rxPop    = rxRe && !rxEmpty;
    stb.errClr   = rxRe;
    stb.frmShort = rxShortL;
    stb.frmExtra = rxExtraL;
  end
endmodule

// File: rtl/uart9_dpath.sv
module uart9_dpath
  import uart9_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              txExtra,
  input  logic              serIn,
  input  logic              ctsN,
  output logic              serOut,
  output logic              rxLine,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic [DATA_W-1:0] rxData,
  output logic              rxExtra,
  output logic              rxAvail,
  output logic              errFlag,
  output logic              ctsStat,
  output logic              rtsN,
  output logic              irqN
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // transmit frame assembly and shifter
  logic [FRAME_W-1:0] txFrame;
  logic [FRAME_W-1:0] txSh;

  always_comb begin
    txFrame    = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (!(cfg.shortWord && (i == DATA_W - 1))) txFrame[i + 1] = txData[i];
    end
    if (cfg.extraEn) begin
      if (cfg.shortWord) txFrame[DATA_W] = txExtra;
      else txFrame[DATA_W + 1] = txExtra;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txSh <= '1;
    else if (stb.txLoad) txSh <= txFrame;
    else if (stb.txShift) txSh <= {1'b1, txSh[FRAME_W-1:1]};
  end

  assign serOut = txSh[0];

  // receive line synchroniser and shifter
  logic [1:0]         rxSync;
  logic [ENTRY_W-1:0] rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b11;
      rxSh   <= '0;
    end else begin
      rxSync <= {rxSync[0], serIn};
      if (stb.rxSample) rxSh <= {rxLine, rxSh[ENTRY_W-1:1]};
    end
  end

  assign rxLine = rxSync[1];

  logic [1:0]         shAmt;
  logic [ENTRY_W-1:0] aligned;
  logic [ENTRY_W-1:0] newEntry;

  always_comb begin
    shAmt   = 2'd1 + 2'(stb.frmShort) - 2'(stb.frmExtra);
    aligned = rxSh >> shAmt;
    newEntry = '0;
    if (stb.frmShort) begin
      newEntry[DATA_W-2:0] = aligned[DATA_W-2:0];
      if (stb.frmExtra) newEntry[DATA_W] = aligned[DATA_W-1];
    end else begin
      newEntry[DATA_W-1:0] = aligned[DATA_W-1:0];
      if (stb.frmExtra) newEntry[DATA_W] = aligned[DATA_W];
    end
  end

  // receive queue
  logic [ENTRY_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [CNT_W-1:0]   count;

  always_ff @(posedge clk) begin
    if (stb.rxPush) fifoMem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.rxPush)
        wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (stb.rxPop)
        rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({stb.rxPush, stb.rxPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rxEmpty = (count == '0);
  assign rxFull  = cfg.fifoOff ? !rxEmpty : (count == CNT_W'(FIFO_DEPTH));
  assign rxAvail = !rxEmpty;

  logic [ENTRY_W-1:0] head;
  assign head    = rxEmpty ? '0 : fifoMem[rdPtr];
  assign rxData  = head[DATA_W-1:0];
  assign rxExtra = head[DATA_W];

  // error flag: set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (stb.errSet) errFlag <= 1'b1;
    else if (stb.errClr) errFlag <= 1'b0;
  end

  // modem lines and interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctsStat <= 1'b0;
    else ctsStat <= !ctsN;
  end

  assign rtsN = !cfg.rtsOn;
  assign irqN = !((cfg.maskRx && rxAvail) || (cfg.maskExtra && rxExtra) ||
                  (cfg.maskErr && errFlag));
endmodule

// File: rtl/uart9_core.sv
module uart9_core
  import uart9_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       cfgWe,
  input  logic [6:0] cfgData,
  input  logic       txWe,
  input  logic [7:0] txData,
  input  logic       txExtra,
  output logic       txBusy,
  input  logic       rxRe,
  output logic [7:0] rxData,
  output logic       rxExtra,
  output logic       rxAvail,
  output logic       errFlag,
  input  logic       serIn,
  output logic       serOut,
  input  logic       ctsN,
  output logic       ctsStat,
  output logic       rtsN,
  output logic       irqN
);
  cfg_t    cfg;
  strobe_t stb;
  logic    rxLine;
  logic    rxFull;
  logic    rxEmpty;

  uart9_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick16),
    .cfgWe   (cfgWe),
    .cfgIn   (cfgData),
    .txWe    (txWe),
    .rxRe    (rxRe),
    .rxLine  (rxLine),
    .rxFull  (rxFull),
    .rxEmpty (rxEmpty),
    .cfg     (cfg),
    .stb     (stb),
    .txBusy  (txBusy)
  );

  uart9_dpath #(.FIFO_DEPTH(FIFO_DEPTH)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .stb     (stb),
    .txData  (txData),
    .txExtra (txExtra),
    .serIn   (serIn),
    .ctsN    (ctsN),
    .serOut  (serOut),
    .rxLine  (rxLine),
    .rxFull  (rxFull),
    .rxEmpty (rxEmpty),
    .rxData  (rxData),
    .rxExtra (rxExtra),
    .rxAvail (rxAvail),
    .errFlag (errFlag),
    .ctsStat (ctsStat),
    .rtsN    (rtsN),
    .irqN    (irqN)
  );
endmodule

// File: rtl/uart9_sva.sv
module uart9_sva (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic       rtsReq,
  input logic       rxRe,
  input logic       rxAvail,
  input logic [7:0] rxData,
  input logic       rxExtra,
  input logic       errFlag,
  input logic       txBusy,
  input logic       serOut,
  input logic       rtsN,
  input logic       irqN
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> serOut); // R1

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rxAvail |-> (rxData == 8'h00 && !rxExtra)); // R8

  AST_DATA_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rxAvail && !rxRe) |=> rxAvail); // R6

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (rxAvail || errFlag)); // R9

  AST_RTS_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (rtsN == !$past(rtsReq))); // R10
endmodule

bind uart9_core uart9_sva sva_i (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWe   (cfgWe),
  .rtsReq  (cfgData[6]),
  .rxRe    (rxRe),
  .rxAvail (rxAvail),
  .rxData  (rxData),
  .rxExtra (rxExtra),
  .errFlag (errFlag),
  .txBusy  (txBusy),
  .serOut  (serOut),
  .rtsN    (rtsN),
  .irqN    (irqN)
);

// File: tb/uart9_core_tb_top.sv
module uart9_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;

  localparam logic [6:0] C_SHORT = 7'h01;
  localparam logic [6:0] C_EXTRA = 7'h02;
  localparam logic [6:0] C_BYP   = 7'h04;
  localparam logic [6:0] C_MRX   = 7'h08;
  localparam logic [6:0] C_MEXT  = 7'h10;
  localparam logic [6:0] C_MERR  = 7'h20;
  localparam logic [6:0] C_RTS   = 7'h40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b1;
  logic       cfgWe = 1'b0;
  logic [6:0] cfgData = '0;
  logic       txWe = 1'b0;
  logic [7:0] txData = '0;
  logic       txExtra = 1'b0;
  logic       txBusy;
  logic       rxRe = 1'b0;
  logic [7:0] rxData;
  logic       rxExtra;
  logic       rxAvail;
  logic       errFlag;
  logic       serIn = 1'b1;
  logic       serOut;
  logic       ctsN = 1'b1;
  logic       ctsStat;
  logic       rtsN;
  logic       irqN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart9_core dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .cfgWe(cfgWe), .cfgData(cfgData),
    .txWe(txWe), .txData(txData), .txExtra(txExtra), .txBusy(txBusy),
    .rxRe(rxRe), .rxData(rxData), .rxExtra(rxExtra), .rxAvail(rxAvail),
    .errFlag(errFlag), .serIn(serIn), .serOut(serOut), .ctsN(ctsN),
    .ctsStat(ctsStat), .rtsN(rtsN), .irqN(irqN)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input logic [6:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic readPop();
    @(negedge clk);
    rxRe = 1'b1;
    @(negedge clk);
    rxRe = 1'b0;
  endtask

  // send one frame on serIn, bit-exact
  task automatic rxSend(input logic [7:0] d, input logic x, input bit shortW,
                        input bit pe, input logic stopVal);
    int nd;
    nd = shortW ? 7 : 8;
    @(negedge clk);
    serIn = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      serIn = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    if (pe) begin
      serIn = x;
      repeat (BIT_CLKS) @(negedge clk);
    end
    serIn = stopVal;
    repeat (BIT_CLKS) @(negedge clk);
    serIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // start a transmission and compare every bit at its centre
  task automatic txFrameCheck(input string tag, input logic [7:0] d, input logic x,
                              input bit shortW, input bit pe);
    logic exp [0:11];
    int n;
    n = 0;
    exp[n] = 1'b0; n++;
    for (int i = 0; i < (shortW ? 7 : 8); i++) begin
      exp[n] = d[i]; n++;
    end
    if (pe) begin
      exp[n] = x; n++;
    end
    exp[n] = 1'b1; n++;
    exp[n] = 1'b1; n++;
    @(negedge clk);
    txWe = 1'b1; txData = d; txExtra = x;
    @(negedge clk);
    txWe = 1'b0;
    repeat (BIT_CLKS / 2) @(negedge clk);
    chk({tag, " busy"}, 16'(txBusy), 16'd1);
    for (int b = 0; b < n; b++) begin
      chk($sformatf("%s bit%0d", tag, b), 16'(serOut), 16'(exp[b]));
      repeat (BIT_CLKS) @(negedge clk);
    end
    chk({tag, " idle"}, 16'(txBusy), 16'd0);
  endtask

  task automatic t_reset();
    chk("R12 rtsN", 16'(rtsN), 16'd1);
    chk("R12 irqN", 16'(irqN), 16'd1);
    chk("R12 serOut", 16'(serOut), 16'd1);
    chk("R12 rxAvail", 16'(rxAvail), 16'd0);
    chk("R12 errFlag", 16'(errFlag), 16'd0);
    chk("R12 txBusy", 16'(txBusy), 16'd0);
  endtask

  task automatic t_tx();
    setCfg(7'h00);
    txFrameCheck("R1 8-bit", 8'hA5, 1'b1, 1'b0, 1'b0);     // R3: extra ignored
    setCfg(C_SHORT | C_EXTRA);
    txFrameCheck("R2 short", 8'hB5, 1'b0, 1'b1, 1'b1);     // bit7 omitted
    setCfg(C_EXTRA);
    txFrameCheck("R3 extra1", 8'h03, 1'b1, 1'b0, 1'b1);
    txFrameCheck("R3 extra0", 8'h01, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_rxBasic();
    setCfg(C_EXTRA);
    rxSend(8'h5A, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 avail", 16'(rxAvail), 16'd1);
    chk("R4 data", 16'(rxData), 16'h5A);
    chk("R4 extra", 16'(rxExtra), 16'd1);
    readPop();
    setCfg(7'h00);
    rxSend(8'hC3, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R4 noext data", 16'(rxData), 16'hC3);
    chk("R4 noext extra", 16'(rxExtra), 16'd0);
    readPop();
    setCfg(C_SHORT);
    rxSend(8'hFF, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R5 short data", 16'(rxData), 16'h7F);
    readPop();
    setCfg(C_SHORT | C_EXTRA);
    rxSend(8'h2A, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R5 short+ext data", 16'(rxData), 16'h2A);
    chk("R4 short+ext extra", 16'(rxExtra), 16'd1);
    readPop();
    chk("R8 empty avail", 16'(rxAvail), 16'd0);
  endtask

  task automatic t_fifo();
    setCfg(7'h00);
    for (int i = 0; i < 8; i++) rxSend(8'(i * 17 + 1), 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 full no err", 16'(errFlag), 16'd0);
    rxSend(8'hEE, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 overrun err", 16'(errFlag), 16'd1);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R6 order %0d", i), 16'(rxData), 16'(8'(i * 17 + 1)));
      chk($sformatf("R6 avail %0d", i), 16'(rxAvail), 16'd1);
      readPop();
    end
    chk("R8 last read avail", 16'(rxAvail), 16'd0);
    chk("R8 empty data", 16'(rxData), 16'h00);
    chk("R13 err cleared", 16'(errFlag), 16'd0);
  endtask

  task automatic t_bypass();
    setCfg(C_BYP);
    rxSend(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 no err", 16'(errFlag), 16'd0);
    rxSend(8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 err", 16'(errFlag), 16'd1);
    chk("R7 first kept", 16'(rxData), 16'h11);
    readPop();
    chk("R7 second dropped", 16'(rxAvail), 16'd0);
    chk("R8 zero", 16'(rxData), 16'h00);
  endtask

  task automatic t_frameErr();
    setCfg(7'h00);
    rxSend(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (BIT_CLKS) @(negedge clk);
    chk("R11 err", 16'(errFlag), 16'd1);
    chk("R11 discarded", 16'(rxAvail), 16'd0);
    readPop();
    chk("R13 clear on read", 16'(errFlag), 16'd0);
  endtask

  task automatic t_irq();
    setCfg(7'h00);
    rxSend(8'h44, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 unmasked", 16'(irqN), 16'd1);
    setCfg(C_MRX);
    chk("R9 rx mask", 16'(irqN), 16'd0);
    readPop();
    chk("R9 rx cleared", 16'(irqN), 16'd1);
    setCfg(C_MEXT | C_EXTRA);
    rxSend(8'h01, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R9 extra set", 16'(irqN), 16'd0);
    readPop();
    rxSend(8'h02, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 extra clear", 16'(irqN), 16'd1);
    readPop();
    setCfg(C_MERR);
    rxSend(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (BIT_CLKS) @(negedge clk);
    chk("R9 err irq", 16'(irqN), 16'd0);
    readPop();
    chk("R9 err irq cleared", 16'(irqN), 16'd1);
  endtask

  task automatic t_modem();
    setCfg(C_RTS);
    chk("R10 rts on", 16'(rtsN), 16'd0);
    setCfg(7'h00);
    chk("R10 rts off", 16'(rtsN), 16'd1);
    chk("R10 cts idle", 16'(ctsStat), 16'd0);
    ctsN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 cts low", 16'(ctsStat), 16'd1);
    ctsN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 cts high", 16'(ctsStat), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx();
    t_rxBasic();
    t_fifo();
    t_bypass();
    t_frameErr();
    t_irq();
    t_modem();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule